// File: doc/BRIEF.md
# Dual PWM Audio Oscillator Voice

The block is a single synthesizer voice that turns a 12-bit pitch word into two audio waveforms, each delivered as a one-bit pulse-width-modulated line. A 16-bit phase accumulator advances by the pitch word once per PWM carrier period. The upper bits of that phase form two wave samples. The first output carries a unipolar square wave whose peak level follows an 8-bit amplitude value supplied by an external envelope source. The second output carries a rising ramp that is not scaled.

Both carriers share one free-running 8-bit counter that runs from 0 to 254, so each carrier period is 255 clock cycles long. New sample values take effect only at the counter wrap, so a pulse width never changes partway through a period. Each output is driven high while the counter is below the sample that is currently held. An external RC filter then recovers the audio. To get a square wave of constant amplitude, the envelope source holds the amplitude input at a fixed value.

Top module: `pwm_voice`

## Requirements
- R1: While `rst_ni` is low, both outputs are low, the counter is 0, the phase is 0 and both held samples are 0. Because the held samples start at 0, both outputs stay low for the whole first carrier period after reset is released.
- R2: The carrier counter starts at 0 after reset and increases by one on each clock. After the value 254 it returns to 0, so one carrier period is exactly 255 cycles.
- R3: On the clock edge that ends a period (the counter at 254), the phase becomes (phase + `freq_i`) mod 65536. At all other edges the phase does not change.
- R4: The ramp sample taken at a period end is bits [15:8] of the new phase. During the following period `pwm_ramp_o` is high for exactly that many cycles.
- R5: The square sample taken at a period end is `env_i` when bit 15 of the new phase is 1, and 0 when that bit is 0. During the following period `pwm_sq_o` is high for exactly that many cycles.
- R6: The block reads `freq_i` and `env_i` only on the clock edge that ends a period. Changes at any other cycle have no effect on either output during the current period.
- R7: Within a period, an output is high in the cycles where the counter value is below its held sample. A sample of 0 holds the output low for the whole period, and a sample of 255 holds it high for the whole period.
- R8: With `env_i` held at 255, every square period is either fully high or fully low. The square wave then has a constant amplitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_i | input | 12 | Pitch word added to the phase once per carrier period |
| env_i | input | 8 | Amplitude level from the envelope source, applied to the square path |
| pwm_sq_o | output | 1 | PWM line carrying the envelope-scaled square wave |
| pwm_ramp_o | output | 1 | PWM line carrying the unscaled ramp |

## Verification
The risky coincidence is on the wrap cycle. In that one cycle the phase is updated, both samples are latched, and the comparator starts a new period, all while the inputs may be changing. The bench changes `freq_i` and `env_i` at random cycles, including cycles next to a period end. It compares every output cycle against a model that samples the inputs only at the end of a period. It also counts the high cycles in each period and checks that count against the expected sample. A sample taken from the old phase, or an input picked up in the middle of a period, therefore shows up both as a level mismatch in a single cycle and as a wrong duty count.

// File: rtl/pwm_voice_pkg.sv
package pwm_voice_pkg;
  typedef enum logic [0:0] {
    WAVE_SQUARE = 1'b0,
    WAVE_RAMP   = 1'b1
  } wave_e;
endpackage

// File: rtl/pwm_voice_carrier.sv
module pwm_voice_carrier #(
  parameter int PWM_W   = 8,
  parameter int PWM_MAX = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [PWM_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [PWM_W-1:0] LAST = PWM_W'(PWM_MAX - 1);

  logic [PWM_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/pwm_voice_phase.sv
module pwm_voice_phase #(
  parameter int FREQ_W  = 12,
  parameter int PHASE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [FREQ_W-1:0]  freq_i,
  output logic [PHASE_W-1:0] phase_next_o
);
  logic [PHASE_W-1:0] phase_q;

  // wraps modulo 2**PHASE_W
  assign phase_next_o = phase_q + PHASE_W'(freq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (step_i) phase_q <= phase_next_o;
  end

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(phase_q)); // R3
endmodule

// File: rtl/pwm_voice_chan.sv
module pwm_voice_chan
  import pwm_voice_pkg::*;
#(
  parameter wave_e WAVE    = WAVE_SQUARE,
  parameter int    PHASE_W = 16,
  parameter int    PWM_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [PWM_W-1:0]   env_i,
  input  logic [PWM_W-1:0]   cnt_i,
  output logic               pwm_o
);
  logic [PWM_W-1:0] shaped;
  logic [PWM_W-1:0] sample_q;

  generate
    if (WAVE == WAVE_SQUARE) begin : g_square
      assign shaped = phase_i[PHASE_W-1] ? env_i : '0;
    end else begin : g_ramp
      assign shaped = phase_i[PHASE_W-1 -: PWM_W];
    end
  endgenerate

  // duty only changes at carrier wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sample_q <= '0;
    else if (step_i) sample_q <= shaped;
  end

  assign pwm_o = (cnt_i < sample_q);

  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(sample_q)); // R6
  AST_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_q == '0) |-> !pwm_o); // R7
  AST_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_q == '1) |-> pwm_o); // R7
endmodule

// File: rtl/pwm_voice.sv
module pwm_voice
  import pwm_voice_pkg::*;
#(
  parameter int FREQ_W  = 12,
  parameter int PHASE_W = 16,
  parameter int PWM_W   = 8,
  parameter int PWM_MAX = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [PWM_W-1:0]  env_i,
  output logic              pwm_sq_o,
  output logic              pwm_ramp_o
);
  localparam int N_CH = 2;

  logic [PWM_W-1:0]   cnt;
  logic               wrap;
  logic [PHASE_W-1:0] phase_next;
  logic [N_CH-1:0]    pwm;

  pwm_voice_carrier #(
    .PWM_W  (PWM_W),
    .PWM_MAX(PWM_MAX)
  ) u_carrier (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  pwm_voice_phase #(
    .FREQ_W (FREQ_W),
    .PHASE_W(PHASE_W)
  ) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (wrap),
    .freq_i      (freq_i),
    .phase_next_o(phase_next)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam wave_e KIND = (ch == 0) ? WAVE_SQUARE : WAVE_RAMP;
    pwm_voice_chan #(
      .WAVE   (KIND),
      .PHASE_W(PHASE_W),
      .PWM_W  (PWM_W)
    ) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (wrap),
      .phase_i(phase_next),
      .env_i  (env_i),
      .cnt_i  (cnt),
      .pwm_o  (pwm[ch])
    );
  end

  assign pwm_sq_o   = pwm[0];
  assign pwm_ramp_o = pwm[1];

  AST_PERIOD_OPENS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !phase_next[PHASE_W-1]) |=> !pwm_sq_o); // R5
endmodule

// File: tb/pwm_voice_bench.sv
`timescale 1ns/1ps
module pwm_voice_bench;
  localparam int PWM_MAX = 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] freq = '0;
  logic [7:0]  env = '0;
  logic        pwm_sq, pwm_rp;

  pwm_voice u_pwm_voice (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .freq_i    (freq),
    .env_i     (env),
    .pwm_sq_o  (pwm_sq),
    .pwm_ramp_o(pwm_rp)
  );

  always #2.5 clk = ~clk;

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_req = "R1";

  int          m_cnt, m_sq, m_rp, hi_sq, hi_rp;
  logic [15:0] m_phase;
  bit          per_valid;

  function automatic int ramp_sample(logic [15:0] ph);
    return int'(ph[15:8]);
  endfunction

  function automatic int sq_sample(logic [15:0] ph, logic [7:0] e);
    return ph[15] ? int'(e) : 0;
  endfunction

  function automatic int exp_level(int cnt, int smp);
    return (cnt < smp) ? 1 : 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_phase = '0; m_sq = 0; m_rp = 0;
    hi_sq = 0; hi_rp = 0; per_valid = 0;
  endtask

  // one clock: model update after the edge, compare at the falling edge
  task automatic cycle();
    @(posedge clk);
    if (rst_n) begin
      if (m_cnt == PWM_MAX - 1) begin
        m_phase = m_phase + 16'(freq);
        m_rp    = ramp_sample(m_phase);
        m_sq    = sq_sample(m_phase, env);
        m_cnt   = 0;
      end else begin
        m_cnt++;
      end
    end
    @(negedge clk);
    check(cur_req, "square level", int'(pwm_sq), exp_level(m_cnt, m_sq));
    check(cur_req, "ramp level", int'(pwm_rp), exp_level(m_cnt, m_rp));
    if (m_cnt == 0) begin
      hi_sq = 0; hi_rp = 0; per_valid = 1;
    end
    hi_sq += int'(pwm_sq);
    hi_rp += int'(pwm_rp);
    if (m_cnt == PWM_MAX - 1 && per_valid) begin
      check("R5", "square duty", hi_sq, m_sq);  // R5 duty count
      check("R4", "ramp duty", hi_rp, m_rp);    // R4 duty count
    end
  endtask

  task automatic run_periods(int n);
    repeat (n * PWM_MAX) cycle();
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #1;
    check("R1", "square in reset", int'(pwm_sq), 0);
    check("R1", "ramp in reset", int'(pwm_rp), 0);
    repeat (2) @(negedge clk);
    check("R1", "square held reset", int'(pwm_sq), 0);
    check("R1", "ramp held reset", int'(pwm_rp), 0);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    apply_reset();

    // R1: first period after reset stays low; R3: zero pitch holds phase
    cur_req = "R1";
    freq = 12'h000; env = 8'd200;
    run_periods(1);
    cur_req = "R3";
    run_periods(3);
    // R3: phase step of 0x100 raises the ramp by one each period
    freq = 12'h100;
    run_periods(6);

    // R8: full envelope, fast pitch, phase wraps past 65535
    cur_req = "R8";
    freq = 12'hFFF; env = 8'd255;
    run_periods(20);

    // R5: zero envelope keeps square low
    cur_req = "R5";
    freq = 12'h9A7; env = 8'd0;
    run_periods(4);

    // R2: steady period structure
    cur_req = "R2";
    freq = 12'h800; env = 8'd128;
    run_periods(10);

    // R6: inputs change at random cycles within periods
    cur_req = "R6";
    repeat (150 * PWM_MAX) begin
      cycle();
      if ($urandom_range(15) == 0) begin
        freq = 12'($urandom);
        env  = 8'($urandom);
      end
    end

    // R6: change inputs one cycle before wrap and just after
    for (int k = 0; k < 8; k++) begin
      while (m_cnt != PWM_MAX - 2) cycle();
      freq = 12'($urandom); env = 8'($urandom);
      cycle();
      cycle();
      freq = 12'($urandom); env = 8'($urandom);
    end

    // R7: pitch 0xF00 reaches ramp sample 255 (always high) after 17 periods
    cur_req = "R7";
    apply_reset();
    freq = 12'hF00; env = 8'd1;
    run_periods(20);

    // R1: reset in mid run
    apply_reset();
    cur_req = "R1";
    freq = 12'h321; env = 8'd77;
    run_periods(2);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule